// File: doc/BRIEF.md
# BCD Latch Segment Decoder

This block stores one binary-coded decimal digit in a clocked register and turns the stored value into the seven segment drive signals for one display digit. The register is transparent on each clock edge while the load input is high. While the load input is low, the register keeps its code, and the display keeps showing that code whatever happens on the data input.

Only the codes 0 through 9 light segments. Any code from 10 to 15 gives an unlit digit, and a separate blank input turns the digit off for any code. A polarity bit then inverts all seven outputs at once, so the same block can drive a common-cathode LED (polarity 0) or a common-anode LED (polarity 1). For a liquid crystal digit, the polarity follows a 50% duty square wave that is also driven onto the display backplane. The square wave can come from a pin or from an internal divider of the system clock. A select input chooses between the two, and the chosen polarity always appears on the backplane output.

Top module: `bcd_seg_driver`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the stored code to 0. With `load_en`, `blank` and the selected polarity all 0, the first cycle after reset shows 7'h3F on `seg_out`.
- R2: When `load_en` is 1 at a rising clock edge, that edge captures `bcd_in`. `seg_out` shows the new code in the following cycle.
- R3: While `load_en` is 0, the stored code does not change, and changes on `bcd_in` have no effect on `seg_out`.
- R4: Bit i of `seg_out` drives segment i in the order a=0, b=1, c=2, d=3, e=4, f=5, g=6. With polarity 0 the lit sets are: 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=acdefg, 7=abc, 8=abcdefg, 9=abcdfg.
- R5: The stored codes 10 to 15 give a digit with no lit segment.
- R6: When `blank` is 1, no segment is lit, whatever the stored code or `load_en`. `blank` acts on the output without waiting for a clock edge.
- R7: When the selected polarity is 1, `seg_out` is the bitwise inverse of the polarity-0 pattern. This includes the unlit pattern, so it reads 7'h7F.
- R8: With `phase_sel` = 1, the polarity comes from an internal square wave. The wave is 0 after reset and toggles every PHASE_HALF clock edges, counted from the release of reset.
- R9: `backplane` always equals the selected polarity: `phase_ext` when `phase_sel` is 0, the internal wave when `phase_sel` is 1. A lit segment is therefore driven opposite to `backplane`, and an unlit one equal to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bcd_in | input | 4 | Digit code to capture |
| load_en | input | 1 | 1: register follows `bcd_in`; 0: register holds |
| blank | input | 1 | 1: all segments unlit |
| phase_ext | input | 1 | External polarity / square wave |
| phase_sel | input | 1 | 0: use `phase_ext`; 1: use internal square wave |
| seg_out | output | 7 | Segment drive, bit 0 = a through bit 6 = g |
| backplane | output | 1 | Selected polarity for the display common |

## Verification
Only the segment pattern makes the stored code visible. A wrong held value therefore shows up as a wrong glyph in the first cycle after the offending edge, unless `blank` hides it. For that reason the hold checks run with `blank` low. An error in the internal divider shows up on `backplane`, and as a full inversion of `seg_out`, within PHASE_HALF cycles of the misplaced toggle. The sweep covers every code against both blank values and both polarities, so a wrong table entry or a misplaced inversion appears at once in the cycle where that combination is applied.

// File: rtl/bcd_seg_pkg.sv
package bcd_seg_pkg;
  localparam int DIGIT_W = 4;
  localparam int SEG_N   = 7;
  localparam int LAST_DECIMAL = 9;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [SEG_N-1:0]   seg_t;

  // Segment bit order: a=0, b=1, c=2, d=3, e=4, f=5, g=6.
  function automatic seg_t glyph_of(digit_t code);
    seg_t s;
    case (code)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = '0;
    endcase
    return s;
  endfunction

  function automatic logic is_decimal(digit_t code);
    return code <= digit_t'(LAST_DECIMAL);
  endfunction
endpackage

// File: rtl/bcd_hold_reg.sv
module bcd_hold_reg
  import bcd_seg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load_en,
  input  digit_t d_in,
  output digit_t q_out
);
  always_ff @(posedge clk) begin
    if (rst)          q_out <= '0;
    else if (load_en) q_out <= d_in;
  end
endmodule

// File: rtl/bcd_seg_decode.sv
module bcd_seg_decode
  import bcd_seg_pkg::*;
(
  input  digit_t code,
  input  logic   blank,
  input  logic   polarity,
  output logic   legal,
  output seg_t   seg
);
  seg_t lit;

  always_comb begin
    legal = is_decimal(code);
    lit   = (blank || !legal) ? '0 : glyph_of(code);
    seg   = lit ^ {SEG_N{polarity}};
  end
endmodule

// File: rtl/seg_phase_gen.sv
module seg_phase_gen #(
  parameter int PHASE_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  output logic phase_o
);
  localparam int CNT_W = (PHASE_HALF > 1) ? $clog2(PHASE_HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_HALF - 1);

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      phase_o <= 1'b0;
    end else if (wrap) begin
      cnt     <= '0;
      phase_o <= ~phase_o;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bcd_seg_driver.sv
module bcd_seg_driver
  import bcd_seg_pkg::*;
#(
  parameter int PHASE_HALF    = 4,
  parameter bit USE_INT_PHASE = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] bcd_in,
  input  logic       load_en,
  input  logic       blank,
  input  logic       phase_ext,
  input  logic       phase_sel,
  output logic [6:0] seg_out,
  output logic       backplane
);
  digit_t held_code;
  logic   phase_int;
  logic   phase_now;
  logic   code_legal;

  bcd_hold_reg u_hold (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .d_in    (bcd_in),
    .q_out   (held_code)
  );

  generate
    if (USE_INT_PHASE) begin : g_int_phase
      seg_phase_gen #(.PHASE_HALF(PHASE_HALF)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .phase_o (phase_int)
      );
    end else begin : g_no_int_phase
      assign phase_int = 1'b0;
    end
  endgenerate

  assign phase_now = phase_sel ? phase_int : phase_ext;
  assign backplane = phase_now;

  bcd_seg_decode u_dec (
    .code     (held_code),
    .blank    (blank),
    .polarity (phase_now),
    .legal    (code_legal),
    .seg      (seg_out)
  );
endmodule

// File: rtl/bcd_seg_driver_chk.sv
module bcd_seg_driver_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] bcd_in,
  input logic       load_en,
  input logic       blank,
  input logic [3:0] held_code,
  input logic       code_legal,
  input logic [6:0] seg_out,
  input logic       backplane
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> held_code == 4'd0);

  // R2
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> held_code == $past(bcd_in));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(held_code));

  // R5
  illegal_dark_chk: assert property (@(posedge clk) disable iff (rst)
    !code_legal |-> seg_out == {7{backplane}});

  // R6
  blank_dark_chk: assert property (@(posedge clk) disable iff (rst)
    blank |-> seg_out == {7{backplane}});

  // R9
  eight_lit_chk: assert property (@(posedge clk) disable iff (rst)
    (!blank && held_code == 4'd8) |-> seg_out == {7{!backplane}});
endmodule

bind bcd_seg_driver bcd_seg_driver_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bcd_in     (bcd_in),
  .load_en    (load_en),
  .blank      (blank),
  .held_code  (held_code),
  .code_legal (code_legal),
  .seg_out    (seg_out),
  .backplane  (backplane)
);

// File: tb/bcd_seg_driver_tb.sv
module bcd_seg_driver_tb;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] bcd_in;
  logic       load_en;
  logic       blank;
  logic       phase_ext;
  logic       phase_sel;
  logic [6:0] seg_out;
  logic       backplane;

  always #4 clk = ~clk;

  bcd_seg_driver #(.PHASE_HALF(HALF)) u_dut (
    .clk(clk), .rst(rst), .bcd_in(bcd_in), .load_en(load_en),
    .blank(blank), .phase_ext(phase_ext), .phase_sel(phase_sel),
    .seg_out(seg_out), .backplane(backplane)
  );

  typedef struct {
    logic [6:0] pat;
    logic       sel;
    logic       ext;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad   = 0;
  int   edges = 0;
  logic [3:0] model_code = 4'd0;
  bit   done = 0;

  // Glyphs written as segment letters; bit index = letter - "a".
  function automatic logic [6:0] letters(string s);
    logic [6:0] r = '0;
    for (int i = 0; i < s.len(); i++) r[s[i] - 8'h61] = 1'b1;
    return r;
  endfunction

  function automatic logic [6:0] glyph(logic [3:0] c);
    case (c)
      0: return letters("abcdef");
      1: return letters("bc");
      2: return letters("abdeg");
      3: return letters("abcdg");
      4: return letters("bcfg");
      5: return letters("acdfg");
      6: return letters("acdefg");
      7: return letters("abc");
      8: return letters("abcdefg");
      9: return letters("abcdfg");
      default: return 7'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) edges <= 0;
    else     edges <= edges + 1;
  end

  task automatic step(input logic [3:0] c, input logic ld, input logic blk,
                      input logic sel, input logic ext, input string tag);
    exp_t e;
    @(negedge clk);
    bcd_in = c; load_en = ld; blank = blk; phase_sel = sel; phase_ext = ext;
    if (ld) model_code = c;
    e.pat = blk ? 7'h00 : glyph(model_code);
    e.sel = sel; e.ext = ext; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor / scoreboard
  initial begin
    exp_t e;
    logic ph;
    logic [6:0] want;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        ph = e.sel ? logic'((edges / HALF) % 2) : e.ext;
        want = e.pat ^ {7{ph}};
        total++;
        if (seg_out !== want || backplane !== ph) begin
          bad++;
          $display("FAIL %s: seg=%h bp=%b expected seg=%h bp=%b",
                   e.tag, seg_out, backplane, want, ph);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: running expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    string t;
    rst = 1'b1; bcd_in = 4'd7; load_en = 1'b0; blank = 1'b0;
    phase_ext = 1'b0; phase_sel = 1'b0;
    repeat (3) @(negedge clk);
    model_code = 4'd0;
    rst = 1'b0;
    // R1: reset leaves code 0 held
    step(4'd5, 1'b0, 1'b0, 1'b0, 1'b0, "R1");

    // Sweep: R4 decimal, R5 illegal, R6 blank, R7 inversion
    for (int c = 0; c < 16; c++)
      for (int p = 0; p < 2; p++)
        for (int b = 0; b < 2; b++) begin
          t = (b == 1) ? "R6" : ((c > 9) ? "R5" : "R4");
          if (p == 1) t = {t, "/R7"};
          step(4'(c), 1'b1, 1'(b), 1'b0, 1'(p), t);
        end

    // R2 capture then R3 hold while input moves
    step(4'd3, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
    step(4'd8, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    step(4'd5, 1'b0, 1'b0, 1'b0, 1'b1, "R3");
    step(4'd12, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    step(4'd6, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
    step(4'd1, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
    step(4'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R3");

    // R8/R9 internal square wave across several toggles
    for (int k = 0; k < 4 * HALF + 3; k++)
      step(4'(k % 10), 1'b1, 1'(k % 3 == 0), 1'b1, 1'(k % 2), "R8/R9");

    // R9 external polarity again with ext toggling
    for (int k = 0; k < 4; k++)
      step(4'd2, 1'b0, 1'b0, 1'b0, 1'(k % 2), "R9");

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule